// File: doc/BRIEF.md
# Time-Base Counter with Overflow Flag and Idle Wake

This block is the real-time base of a small 4-bit controller. An 8-bit up-counter advances once per tick. Each time it wraps, it raises an overflow flag. The processor polls the flag with a test strobe. When the flag is up, the test answers with a skip request for the next instruction and lowers the flag at the same time.

Software loads the counter in one strobe. The upper half of the new value comes from the accumulator nibble and the lower half from the RAM nibble. A loaded value whose top bit is set raises the flag at once.

An idle request asserts `halt`, which freezes the rest of the processor. During idle only the counter keeps running, and the block leaves idle on the next wrap. A static parameter selects the tick source. The counter counts either a single-cycle time-base enable or rising edges of an external event input.

Top module: `tbase_timer`

## Requirements
- R1: After reset, `count` is 0x00, `halt` is 0 and the overflow flag is clear, so a test strobe returns `skip_req` = 0.
- R2: Each cycle with an active tick adds 1 to `count`, and the value after 0xFF is 0x00. A cycle without a tick leaves `count` unchanged.
- R3: The wrap from 0xFF to 0x00 sets the overflow flag.
- R4: `skip_req` is combinational. It is 1 in a cycle where `test_stb` is high and the flag is set, and the flag is cleared at that clock edge. With the flag clear, `skip_req` stays 0.
- R5: `load_stb` writes `{acc_nib, ram_nib}` into the counter (accumulator in bits 7:4, RAM in bits 3:0), visible after that edge. A load takes priority over a tick in the same cycle.
- R6: A load with `acc_nib[3]` = 1 (counter bit 7) sets the overflow flag at that edge.
- R7: `idle_req` moves the controller from RUN to IDLE, and `halt` is 1 from the next cycle on. IDLE returns to RUN on the edge where the counter wraps, so `halt` is 0 after that edge. The flag stays set after the exit, and a later test reports it.
- R8: While `halt` is 1, `load_stb`, `test_stb` and `idle_req` have no effect, `skip_req` stays 0, and the counter keeps counting ticks.
- R9: With `EXT_EVENTS` = 0 the tick is `base_tick`. With `EXT_EVENTS` = 1 the tick is a rising edge of `event_in`, counted once per edge, and `base_tick` is ignored.
- R10: If a wrap or a loaded set bit 7 coincides with a test that clears the flag, the set wins, and the flag remains set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_stb | input | 1 | Load the counter from the two nibbles |
| acc_nib | input | 4 | Accumulator nibble, goes to counter bits 7:4 |
| ram_nib | input | 4 | RAM nibble, goes to counter bits 3:0 |
| test_stb | input | 1 | Test and clear the overflow flag |
| idle_req | input | 1 | Enter idle until the next wrap |
| base_tick | input | 1 | Internal time-base enable |
| event_in | input | 1 | External event level |
| skip_req | output | 1 | Skip the next instruction |
| count | output | 8 | Current counter value |
| halt | output | 1 | Freeze the processor |

## Verification
The flag is set in three ways: by a counted wrap, by a load with bit 7 set, and by a wrap in the same cycle as a clearing test. Each is followed by back-to-back tests, which show whether the flag is cleared and whether the set has priority. A load in the same cycle as a tick shows whether the load takes priority.

The idle run starts from a known value and checks the exact number of cycles until `halt` falls. A load and a test injected mid-idle would change that number, or raise a skip, if they leaked through.

A second instance in event mode gets time-base ticks, single-cycle pulses and a held-high level. This shows whether it counts edges of `event_in` only.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_IDLE = 1'b1
    } idle_state_e;
endpackage

// File: rtl/tbase_tick_src.sv
module tbase_tick_src #(
    parameter bit EXT_EVENTS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic base_tick,
    input  logic event_in,
    output logic tick
);
    generate
        if (EXT_EVENTS) begin : g_ext
            logic ev_q;
            always_ff @(posedge clk) begin
                if (!rst_n) ev_q <= 1'b0;
                else        ev_q <= event_in;
            end
            assign tick = event_in & ~ev_q;

            // R9: a held-high level produces only one tick
            a_r9_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end else begin : g_int
            assign tick = base_tick;
        end
    endgenerate
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int CNT_W = 8,
    localparam int NIB_W = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [NIB_W-1:0] hi_nib,
    input  logic [NIB_W-1:0] lo_nib,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= {hi_nib, lo_nib};
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = tick & ~load & (&cnt_q);

    // R2: a counted tick advances by one
    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));
    // R2: no tick, no load, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
    // R5: load writes both nibbles
    a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt_q == $past({hi_nib, lo_nib}));
endmodule

// File: rtl/tbase_ovf_flag.sv
module tbase_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic load_msb,
    input  logic test,
    output logic flag
);
    logic flag_q;
    logic set_any;

    assign set_any = wrap | load_msb;

    always_ff @(posedge clk) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (set_any) flag_q <= 1'b1;
        else if (test)    flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R3: wrap sets the flag
    a_r3_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag_q);
    // R6: loaded bit 7 sets the flag
    a_r6_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
        load_msb |=> flag_q);
    // R4: a test without a coinciding set clears the flag
    a_r4_test_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (test && !wrap && !load_msb) |=> !flag_q);
    // R10: without set or test the flag holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!test && !wrap && !load_msb) |=> $stable(flag_q));
endmodule

// File: rtl/tbase_idle_ctl.sv
module tbase_idle_ctl
    import tbase_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic wrap,
    output logic halt
);
    idle_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (idle_req) state_d = ST_IDLE;
            ST_IDLE: if (wrap)     state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: halt = 1'b1;
            default: halt = 1'b0;
        endcase
    end

    // R7: idle persists until a wrap
    a_r7_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wrap) |=> halt);
    // R7: a wrap during idle wakes
    a_r7_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wrap) |=> !halt);
    // R7: request from run enters idle
    a_r7_enter: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && idle_req) |=> halt);
endmodule

// File: rtl/tbase_timer.sv
module tbase_timer #(
    parameter int CNT_W      = 8,
    parameter bit EXT_EVENTS = 1'b0,
    localparam int NIB_W     = CNT_W / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [NIB_W-1:0] acc_nib,
    input  logic [NIB_W-1:0] ram_nib,
    input  logic             test_stb,
    input  logic             idle_req,
    input  logic             base_tick,
    input  logic             event_in,
    output logic             skip_req,
    output logic [CNT_W-1:0] count,
    output logic             halt
);
    logic tick;
    logic wrap;
    logic flag;
    logic load_g;
    logic test_g;
    logic idle_g;

    assign load_g = load_stb & ~halt;
    assign test_g = test_stb & ~halt;
    assign idle_g = idle_req & ~halt;

    tbase_tick_src #(.EXT_EVENTS(EXT_EVENTS)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_tick (base_tick),
        .event_in  (event_in),
        .tick      (tick)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .load   (load_g),
        .hi_nib (acc_nib),
        .lo_nib (ram_nib),
        .cnt    (count),
        .wrap   (wrap)
    );

    tbase_ovf_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .load_msb (load_g & acc_nib[NIB_W-1]),
        .test     (test_g),
        .flag     (flag)
    );

    tbase_idle_ctl u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .idle_req (idle_g),
        .wrap     (wrap),
        .halt     (halt)
    );

    assign skip_req = test_g & flag;

    // R8: no skip while halted
    a_r8_no_skip_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !skip_req);
    // R8: a halted load does not replace the count
    a_r8_load_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !tick) |=> $stable(count));
endmodule

// File: tb/tbase_timer_test.sv
module tbase_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load_stb = 1'b0;
    logic [3:0] acc_nib = 4'h0;
    logic [3:0] ram_nib = 4'h0;
    logic       test_stb = 1'b0;
    logic       idle_req = 1'b0;
    logic       base_tick = 1'b0;
    logic       event_in = 1'b0;
    logic       skip_req, halt;
    logic [7:0] count;
    logic       skip_x, halt_x;
    logic [7:0] count_x;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tbase_timer uut (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .acc_nib(acc_nib),
        .ram_nib(ram_nib), .test_stb(test_stb), .idle_req(idle_req),
        .base_tick(base_tick), .event_in(event_in),
        .skip_req(skip_req), .count(count), .halt(halt)
    );

    tbase_timer #(.EXT_EVENTS(1'b1)) uut_ext (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .acc_nib(acc_nib),
        .ram_nib(ram_nib), .test_stb(test_stb), .idle_req(1'b0),
        .base_tick(base_tick), .event_in(event_in),
        .skip_req(skip_x), .count(count_x), .halt(halt_x)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_test(input bit exp, input string req);
        test_stb = 1'b1;
        #1;
        check(skip_req == exp, req, skip_req, exp);
        step();
        test_stb = 1'b0;
    endtask

    task automatic do_load(input logic [7:0] v);
        acc_nib = v[7:4];
        ram_nib = v[3:0];
        load_stb = 1'b1;
        step();
        load_stb = 1'b0;
    endtask

    task automatic t_reset();
        check(count == 8'h00, "R1", count, 0);
        check(halt == 1'b0, "R1", halt, 0);
        do_test(1'b0, "R1");
    endtask

    task automatic t_count();
        base_tick = 1'b1;
        repeat (5) step();
        base_tick = 1'b0;
        check(count == 8'h05, "R2", count, 5);
        repeat (3) step();
        check(count == 8'h05, "R2", count, 5);
    endtask

    task automatic t_load();
        do_load(8'h3A);
        check(count == 8'h3A, "R5", count, 8'h3A);
        do_test(1'b0, "R5");
        base_tick = 1'b1;
        do_load(8'h21);
        base_tick = 1'b0;
        check(count == 8'h21, "R5", count, 8'h21);
    endtask

    task automatic t_wrap();
        do_load(8'h7E);
        base_tick = 1'b1;
        repeat (129) step();
        base_tick = 1'b0;
        check(count == 8'hFF, "R2", count, 8'hFF);
        do_test(1'b0, "R3");
        base_tick = 1'b1;
        step();
        base_tick = 1'b0;
        check(count == 8'h00, "R2", count, 0);
        do_test(1'b1, "R3");
        do_test(1'b0, "R4");
    endtask

    task automatic t_msb();
        do_load(8'h80);
        do_test(1'b1, "R6");
        do_test(1'b0, "R6");
        do_load(8'h7F);
        do_test(1'b0, "R6");
    endtask

    task automatic t_idle();
        int cyc;
        do_load(8'h7C);
        idle_req = 1'b1;
        step();
        idle_req = 1'b0;
        check(halt == 1'b1, "R7", halt, 1);
        base_tick = 1'b1;
        cyc = 0;
        while (halt && cyc < 400) begin
            if (cyc == 10) begin
                acc_nib = 4'hF; ram_nib = 4'hE; load_stb = 1'b1;
            end else if (cyc == 11) begin
                load_stb = 1'b0; test_stb = 1'b1; idle_req = 1'b1;
                #1;
                check(skip_req == 1'b0, "R8", skip_req, 0);
            end else begin
                load_stb = 1'b0; test_stb = 1'b0; idle_req = 1'b0;
            end
            step();
            cyc++;
        end
        base_tick = 1'b0;
        load_stb = 1'b0; test_stb = 1'b0; idle_req = 1'b0;
        check(cyc == 132, "R8", cyc, 132);
        check(count == 8'h00, "R7", count, 0);
        check(halt == 1'b0, "R7", halt, 0);
        do_test(1'b1, "R7");
    endtask

    task automatic t_setwins();
        do_load(8'hFF);
        base_tick = 1'b1;
        do_test(1'b1, "R10");
        base_tick = 1'b0;
        check(count == 8'h00, "R10", count, 0);
        do_test(1'b1, "R10");
        do_test(1'b0, "R10");
    endtask

    task automatic t_ext();
        do_load(8'h00);
        base_tick = 1'b1;
        repeat (4) step();
        base_tick = 1'b0;
        check(count_x == 8'h00, "R9", count_x, 0);
        check(count == 8'h04, "R9", count, 4);
        for (int i = 0; i < 3; i++) begin
            event_in = 1'b1; step();
            event_in = 1'b0; step();
        end
        event_in = 1'b1;
        repeat (3) step();
        event_in = 1'b0;
        step();
        check(count_x == 8'h04, "R9", count_x, 4);
        check(count == 8'h04, "R9", count, 4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_count();
        t_load();
        t_wrap();
        t_msb();
        t_idle();
        t_setwins();
        t_ext();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule